// File: doc/BRIEF.md
# Conversion Result Correction and Output Coding

This block sits behind the decimation filter of a delta-sigma converter. It takes each self-calibrated signed sample and removes a system offset, unless that step is bypassed. It then multiplies by a system gain factor and applies the polarity scale. The result is saturated to a 20-bit range and coded for the host. In bipolar mode the host chooses between two's complement and offset binary. In unipolar mode the result is doubled and coded as straight binary.

The system offset is kept in a 24-bit two's complement register that resets to zero. Software reaches it through a serial port that shifts the most significant bit first in both directions. A calibration sequencer can also load it in one cycle through a parallel port. A loaded value stays in force until the next serial write or calibration load. The mode bits, the gain and the offset are captured together with each sample, so changing them while samples are in flight affects only later samples.

Top module: `adc_result_cond`

## Requirements
- R1: After reset the offset register holds zero, and a serial read of it returns 24 zero bits.
- R2: A serial write frame (select high, write high) shifts 24 bits in on 24 strobes, most significant bit first, and commits the value on the 24th strobe. A serial read frame (select high, write low) presents the bit for the current strobe count on the data output, most significant bit first, and each strobe advances to the next bit.
- R3: A parallel calibration load replaces the offset register in the next cycle. If it coincides with the strobe that completes a serial write, the calibration value is kept.
- R4: The offset register keeps its value through serial reads and through serial write frames that end before 24 strobes. The parallel value input has no effect without its load strobe.
- R5: With the bypass bit at 0 the offset is subtracted from the sample. With the bypass bit at 1 the sample passes on with no offset removed.
- R6: The corrected value is floor(((sample − offset) × gain) / 2^22), where gain is unsigned with 22 fraction bits (0x400000 = 1.0). Offset removal comes before the gain step, and both come before the polarity scale.
- R7: In bipolar mode with the two's complement format selected, the value is clamped to [−524288, 524287] and sent as its 20-bit two's complement code. Zero gives 0x00000, positive saturation gives 0x7FFFF and negative saturation gives 0x80000.
- R8: In bipolar mode with offset binary selected, the code is the two's complement code with bit 19 inverted. Zero gives 0x80000, positive saturation gives 0xFFFFF and negative saturation gives 0x00000.
- R9: In unipolar mode the value is doubled and clamped to [0, 0xFFFFF] as straight binary. The format bit has no effect in this mode.
- R10: The output valid signal repeats the input valid signal exactly 3 cycles later. Mode bits, gain and offset are taken in the cycle the sample is accepted.
- R11: During and after reset the output valid signal and the output code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 24 | Self-calibrated signed sample |
| ofs_sel | input | 1 | Serial frame select for the offset register |
| ofs_wr | input | 1 | Frame direction: 1 write, 0 read |
| ofs_strobe | input | 1 | One serial bit per cycle while high |
| ofs_sdi | input | 1 | Serial write data |
| ofs_sdo | output | 1 | Serial read data |
| cal_load | input | 1 | Parallel offset load strobe |
| cal_value | input | 24 | Parallel offset value |
| ofs_bypass | input | 1 | 1 = skip offset removal |
| unipolar | input | 1 | 1 = unipolar mode (x2 scale) |
| twos_fmt | input | 1 | Bipolar coding: 1 two's complement, 0 offset binary |
| gain | input | 24 | Unsigned gain, 22 fraction bits |
| out_valid | output | 1 | Result strobe |
| out_code | output | 20 | Coded result |

## Verification
Small samples at unity gain show whether the two bipolar codings and the unipolar straight binary are told apart correctly. Samples at exactly ±2^19, just beyond that range, and at the 24-bit extremes show where each mode starts to saturate. A fractional gain combined with a non-zero offset separates offset-before-gain from gain-before-offset, because the two orders give different codes. Random samples, gains and modes change on every sample and the offset is rewritten now and then. This shows that each result uses the settings taken with its own sample and not those of its neighbours.

// File: rtl/adc_result_cond_pkg.sv
`timescale 1ns/1ps
// Shared types and width helpers for the conversion result corrector.
package adc_result_cond_pkg;

    // Coding controls carried along with each sample.
    typedef struct packed {
        logic unipolar;
        logic twos;
    } arc_fmt_t;

    // Width of the difference stage: widest operand plus sign and borrow headroom.
    function automatic int arc_diff_w(input int raw_w, input int ofs_w);
        return ((raw_w > ofs_w) ? raw_w : ofs_w) + 2;
    endfunction

    // Width of the gain product: difference times unsigned gain with a sign bit.
    function automatic int arc_prod_w(input int raw_w, input int ofs_w, input int gain_w);
        return arc_diff_w(raw_w, ofs_w) + gain_w + 1;
    endfunction

endpackage

// File: rtl/arc_offset_reg.sv
`timescale 1ns/1ps
// System offset holding register with a serial MSB-first port and a parallel
// calibration load. Assumes the serial master keeps ser_sel high for a whole
// frame. Dropping ser_sel restarts the bit count and discards a partial write.
module arc_offset_reg #(
    parameter int OFS_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_sel,
    input  logic             ser_wr,
    input  logic             ser_strobe,
    input  logic             ser_sdi,
    output logic             ser_sdo,
    input  logic             cal_load,
    input  logic [OFS_W-1:0] cal_value,
    output logic [OFS_W-1:0] ofs_q
);
    localparam int CNT_W = $clog2(OFS_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(OFS_W - 1);

    logic [CNT_W-1:0] bit_cnt;
    logic [OFS_W-2:0] shreg;
    logic [OFS_W-1:0] ofs_r;
    logic [CNT_W-1:0] rd_idx;
    logic             wr_shift;
    logic             wr_done;

    assign wr_shift = ser_sel && ser_wr && ser_strobe;
    assign wr_done  = wr_shift && (bit_cnt == LAST_BIT);
    assign rd_idx   = LAST_BIT - bit_cnt;
    assign ser_sdo  = ser_sel && !ser_wr && ofs_r[rd_idx];
    assign ofs_q    = ofs_r;

    // Bit position within the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !ser_sel)
            bit_cnt <= '0;
        else if (ser_strobe)
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
    end

    // Collects the leading bits of a write frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (wr_shift)
            shreg <= {shreg[OFS_W-3:0], ser_sdi};
    end

    // Offset value: the calibration load takes priority over a completing write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ofs_r <= '0;
        else if (cal_load)
            ofs_r <= cal_value;
        else if (wr_done)
            ofs_r <= {shreg, ser_sdi};
    end

    // R3
    cal_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_load |=> ofs_r == $past(cal_value));

    // R4
    ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_load && !(ser_sel && ser_wr && ser_strobe)) |=> $stable(ofs_r));

endmodule

// File: rtl/arc_corr_stage.sv
`timescale 1ns/1ps
// Two-stage correction: offset removal (stage 1), then multiplication by the
// unsigned gain (stage 2). The offset, gain and coding bits are taken in the
// same cycle as the sample. Widths leave room so that nothing wraps.
module arc_corr_stage
    import adc_result_cond_pkg::*;
#(
    parameter int RAW_W  = 24,
    parameter int OFS_W  = 24,
    parameter int GAIN_W = 24,
    parameter int PROD_W = arc_prod_w(RAW_W, OFS_W, GAIN_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [RAW_W-1:0]         in_sample,
    input  logic [OFS_W-1:0]         ofs_value,
    input  logic                     ofs_bypass,
    input  logic [GAIN_W-1:0]        gain,
    input  arc_fmt_t                 fmt_in,
    output logic                     p_valid,
    output logic signed [PROD_W-1:0] p_prod,
    output arc_fmt_t                 p_fmt
);
    localparam int DIFF_W = arc_diff_w(RAW_W, OFS_W);

    logic signed [DIFF_W-1:0] samp_x;
    logic signed [DIFF_W-1:0] ofs_x;
    logic signed [DIFF_W-1:0] s1_diff;
    logic        [GAIN_W-1:0] s1_gain;
    arc_fmt_t                 s1_fmt;
    logic                     s1_valid;
    logic signed [GAIN_W:0]   gain_s;

    assign samp_x = DIFF_W'(signed'(in_sample));
    assign ofs_x  = DIFF_W'(signed'(ofs_value));
    assign gain_s = signed'({1'b0, s1_gain});

    // Stage 1: remove the offset unless bypassed and take the settings for this sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_diff  <= '0;
            s1_gain  <= '0;
            s1_fmt   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_diff <= ofs_bypass ? samp_x : samp_x - ofs_x;
                s1_gain <= gain;
                s1_fmt  <= fmt_in;
            end
        end
    end

    // Stage 2: apply the system gain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_valid <= 1'b0;
            p_prod  <= '0;
            p_fmt   <= '0;
        end else begin
            p_valid <= s1_valid;
            if (s1_valid) begin
                p_prod <= PROD_W'(s1_diff) * PROD_W'(gain_s);
                p_fmt  <= s1_fmt;
            end
        end
    end

endmodule

// File: rtl/arc_scale_encode.sv
`timescale 1ns/1ps
// Final stage: drops the gain fraction bits (rounding down), applies the
// polarity scale, saturates to the output range and codes the result. Assumes
// PROD_W leaves at least one spare bit, so the x2 scale cannot wrap.
module arc_scale_encode
    import adc_result_cond_pkg::*;
#(
    parameter int PROD_W    = 51,
    parameter int GAIN_FRAC = 22,
    parameter int OUT_W     = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     p_valid,
    input  logic signed [PROD_W-1:0] p_prod,
    input  arc_fmt_t                 p_fmt,
    output logic                     out_valid,
    output logic [OUT_W-1:0]         out_code
);
    localparam logic signed [PROD_W-1:0] BIP_MAX = PROD_W'((64'sd1 <<< (OUT_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] BIP_MIN = ~BIP_MAX;
    localparam logic signed [PROD_W-1:0] UNI_MAX = PROD_W'((64'sd1 <<< OUT_W) - 1);

    logic signed [PROD_W-1:0] trunc;
    logic signed [PROD_W-1:0] scaled;
    logic        [OUT_W-1:0]  tc_code;
    logic        [OUT_W-1:0]  next_code;

    assign trunc  = p_prod >>> GAIN_FRAC;
    assign scaled = p_fmt.unipolar ? (trunc <<< 1) : trunc;

    // Saturate and pick the output coding.
    always_comb begin
        if (scaled > BIP_MAX)
            tc_code = BIP_MAX[OUT_W-1:0];
        else if (scaled < BIP_MIN)
            tc_code = BIP_MIN[OUT_W-1:0];
        else
            tc_code = scaled[OUT_W-1:0];

        if (p_fmt.unipolar) begin
            if (scaled < 0)
                next_code = '0;
            else if (scaled > UNI_MAX)
                next_code = UNI_MAX[OUT_W-1:0];
            else
                next_code = scaled[OUT_W-1:0];
        end else if (p_fmt.twos) begin
            next_code = tc_code;
        end else begin
            next_code = {~tc_code[OUT_W-1], tc_code[OUT_W-2:0]};
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= p_valid;
            if (p_valid)
                out_code <= next_code;
        end
    end

    // R7
    bip_pos_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && !p_fmt.unipolar && p_fmt.twos && scaled > BIP_MAX)
        |=> out_code == {1'b0, {(OUT_W-1){1'b1}}});

    // R9
    uni_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && p_fmt.unipolar && scaled < 0) |=> out_code == '0);

endmodule

// File: rtl/adc_result_cond.sv
`timescale 1ns/1ps
// Conversion result corrector top: offset register, correction pipeline and
// output coder. Total latency from in_valid to out_valid is 3 cycles.
module adc_result_cond
    import adc_result_cond_pkg::*;
#(
    parameter int RAW_W     = 24,
    parameter int OFS_W     = 24,
    parameter int GAIN_W    = 24,
    parameter int GAIN_FRAC = 22,
    parameter int OUT_W     = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [RAW_W-1:0]  in_sample,
    input  logic              ofs_sel,
    input  logic              ofs_wr,
    input  logic              ofs_strobe,
    input  logic              ofs_sdi,
    output logic              ofs_sdo,
    input  logic              cal_load,
    input  logic [OFS_W-1:0]  cal_value,
    input  logic              ofs_bypass,
    input  logic              unipolar,
    input  logic              twos_fmt,
    input  logic [GAIN_W-1:0] gain,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_code
);
    localparam int PROD_W = arc_prod_w(RAW_W, OFS_W, GAIN_W);

    logic [OFS_W-1:0]         ofs_q;
    arc_fmt_t                 fmt_in;
    arc_fmt_t                 p_fmt;
    logic                     p_valid;
    logic signed [PROD_W-1:0] p_prod;

    assign fmt_in.unipolar = unipolar;
    assign fmt_in.twos     = twos_fmt;

    arc_offset_reg #(.OFS_W(OFS_W)) u_ofs (
        .clk(clk), .rst_n(rst_n),
        .ser_sel(ofs_sel), .ser_wr(ofs_wr), .ser_strobe(ofs_strobe),
        .ser_sdi(ofs_sdi), .ser_sdo(ofs_sdo),
        .cal_load(cal_load), .cal_value(cal_value), .ofs_q(ofs_q)
    );

    arc_corr_stage #(
        .RAW_W(RAW_W), .OFS_W(OFS_W), .GAIN_W(GAIN_W), .PROD_W(PROD_W)
    ) u_corr (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sample(in_sample), .ofs_value(ofs_q),
        .ofs_bypass(ofs_bypass), .gain(gain), .fmt_in(fmt_in),
        .p_valid(p_valid), .p_prod(p_prod), .p_fmt(p_fmt)
    );

    arc_scale_encode #(
        .PROD_W(PROD_W), .GAIN_FRAC(GAIN_FRAC), .OUT_W(OUT_W)
    ) u_enc (
        .clk(clk), .rst_n(rst_n),
        .p_valid(p_valid), .p_prod(p_prod), .p_fmt(p_fmt),
        .out_valid(out_valid), .out_code(out_code)
    );

    // R10
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3))
        |-> out_valid == $past(in_valid, 3));

    // R8
    zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3) &&
         $past(in_valid, 3) && $past(in_sample, 3) == '0 &&
         $past(ofs_bypass, 3) && !$past(unipolar, 3))
        |-> out_code == ($past(twos_fmt, 3) ? '0 : {1'b1, {(OUT_W-1){1'b0}}}));

endmodule

// File: tb/adc_result_cond_tb.sv
`timescale 1ns/1ps
module adc_result_cond_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_sample = '0;
    logic        ofs_sel = 1'b0, ofs_wr = 1'b0, ofs_strobe = 1'b0, ofs_sdi = 1'b0;
    logic        ofs_sdo;
    logic        cal_load = 1'b0;
    logic [23:0] cal_value = '0;
    logic        ofs_bypass = 1'b1, unipolar = 1'b0, twos_fmt = 1'b1;
    logic [23:0] gain = 24'h400000;
    logic        out_valid;
    logic [19:0] out_code;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [23:0] model_ofs = '0;

    typedef struct { logic [19:0] code; int due; string req; } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    adc_result_cond dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .ofs_sel(ofs_sel), .ofs_wr(ofs_wr), .ofs_strobe(ofs_strobe),
        .ofs_sdi(ofs_sdi), .ofs_sdo(ofs_sdo), .cal_load(cal_load),
        .cal_value(cal_value), .ofs_bypass(ofs_bypass), .unipolar(unipolar),
        .twos_fmt(twos_fmt), .gain(gain), .out_valid(out_valid), .out_code(out_code)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Expected code computed from the requirements (R5-R9).
    function automatic logic [19:0] model(input logic signed [23:0] s, input logic signed [23:0] o,
                                          input bit byp, input logic [23:0] g,
                                          input bit uni, input bit twos);
        longint d, p, v;
        logic [19:0] t;
        d = byp ? longint'(s) : longint'(s) - longint'(o);
        p = d * longint'({1'b0, g});
        v = p >>> 22;
        if (uni) begin
            v = v * 2;
            if (v < 0) v = 0;
            else if (v > 1048575) v = 1048575;
            return v[19:0];
        end
        if (v > 524287) v = 524287;
        else if (v < -524288) v = -524288;
        t = v[19:0];
        return twos ? t : (t ^ 20'h80000);
    endfunction

    // One cycle; checks the output stream against the queue (R10 timing).
    task automatic tick();
        exp_t e;
        @(negedge clk);
        cyc++;
        if (out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected out_valid", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check(cyc == e.due, "R10 latency", cyc, e.due);
                check(out_code == e.code, e.req, out_code, e.code);
            end
        end else if (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            e = exp_q.pop_front();
            check(1'b0, "R10 missing out_valid", 0, 1);
        end
    endtask

    task automatic send_exp(input logic [23:0] s, input logic [19:0] code, input string req);
        exp_t e;
        in_valid = 1'b1;
        in_sample = s;
        e.code = code; e.due = cyc + 3; e.req = req;
        exp_q.push_back(e);
        tick();
        in_valid = 1'b0;
    endtask

    task automatic send(input logic [23:0] s, input string req);
        send_exp(s, model(s, model_ofs, ofs_bypass, gain, unipolar, twos_fmt), req);
    endtask

    task automatic drain();
        repeat (5) tick();
    endtask

    task automatic ser_write(input logic [23:0] val, input int nbits, input bit collide,
                             input logic [23:0] calv);
        ofs_sel = 1'b1; ofs_wr = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            ofs_sdi = val[23-i];
            ofs_strobe = 1'b1;
            if (collide && i == 23) begin
                cal_load = 1'b1;
                cal_value = calv;
            end
            tick();
            cal_load = 1'b0;
        end
        ofs_strobe = 1'b0; ofs_sel = 1'b0; ofs_wr = 1'b0;
        tick();
        if (nbits == 24) model_ofs = collide ? calv : val;
    endtask

    task automatic ser_read(output logic [23:0] r);
        ofs_sel = 1'b1; ofs_wr = 1'b0; ofs_strobe = 1'b0;
        tick();
        for (int i = 0; i < 24; i++) begin
            r[23-i] = ofs_sdo;
            ofs_strobe = 1'b1;
            tick();
        end
        ofs_strobe = 1'b0; ofs_sel = 1'b0;
        tick();
    endtask

    task automatic par_load(input logic [23:0] v);
        cal_value = v; cal_load = 1'b1;
        tick();
        cal_load = 1'b0;
        model_ofs = v;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic [23:0] rd;
        void'($urandom(32'd2024));

        // R11: reset state
        repeat (3) tick();
        check(out_valid == 1'b0, "R11 out_valid in reset", out_valid, 0);
        check(out_code == '0, "R11 out_code in reset", out_code, 0);
        rst_n = 1'b1;
        tick();
        check(out_valid == 1'b0 && out_code == '0, "R11 after reset", out_code, 0);

        // R1: offset register reads zero
        ser_read(rd);
        check(rd == '0, "R1 reset offset", rd, 0);

        // R7 / R8: bipolar codes at unity gain, bypass on
        ofs_bypass = 1'b1; unipolar = 1'b0; gain = 24'h400000;
        twos_fmt = 1'b1;
        send_exp(24'h000000, 20'h00000, "R7 zero");
        send_exp(24'h7FFFFF, 20'h7FFFF, "R7 pos sat");
        send_exp(24'h800000, 20'h80000, "R7 neg sat");
        send_exp(24'h07FFFF, 20'h7FFFF, "R7 max in range");
        send_exp(24'h080000, 20'h7FFFF, "R7 just above range");
        send_exp(24'hF80000, 20'h80000, "R7 min in range");
        send_exp(24'hF7FFFF, 20'h80000, "R7 just below range");
        send_exp(24'hFFFFFF, 20'hFFFFF, "R7 minus one");
        twos_fmt = 1'b0;
        send_exp(24'h000000, 20'h80000, "R8 zero");
        send_exp(24'h7FFFFF, 20'hFFFFF, "R8 pos sat");
        send_exp(24'h800000, 20'h00000, "R8 neg sat");
        send_exp(24'hFFFFFF, 20'h7FFFF, "R8 minus one");
        send_exp(24'h000001, 20'h80001, "R8 plus one");
        drain();

        // R9: unipolar, with both settings of the format bit
        unipolar = 1'b1;
        for (int f = 0; f < 2; f++) begin
            twos_fmt = f[0];
            send_exp(24'h040000, 20'h80000, "R9 half scale");
            send_exp(24'h07FFFF, 20'hFFFFE, "R9 near top");
            send_exp(24'h080000, 20'hFFFFF, "R9 top sat");
            send_exp(24'hFFFFFF, 20'h00000, "R9 negative floor");
        end
        drain();

        // R2 / R5: serial write, readback, subtraction and bypass
        ser_write(24'd1000, 24, 1'b0, '0);
        ser_read(rd);
        check(rd == 24'd1000, "R2 readback", rd, 1000);
        unipolar = 1'b0; twos_fmt = 1'b1; ofs_bypass = 1'b0;
        send_exp(24'd1000, 20'h00000, "R5 offset removed");
        send_exp(24'd0, 20'hFFC18, "R5 negative result");
        ofs_bypass = 1'b1;
        send_exp(24'd1000, 20'h003E8, "R5 bypass");
        drain();

        // R6: order of offset, gain and scale
        par_load(24'd3);
        ofs_bypass = 1'b0; unipolar = 1'b1; gain = 24'h200000;
        send_exp(24'd9, 20'h00006, "R6 offset before gain and scale");
        par_load(24'hFFFFFC);
        unipolar = 1'b0; twos_fmt = 1'b1;
        send_exp(24'd5, 20'h00004, "R6 floor of fractional gain");
        drain();

        // R3: calibration load wins a collision with a serial write
        ser_write(24'h123456, 24, 1'b1, 24'h0ABCDE);
        ser_read(rd);
        check(rd == 24'h0ABCDE, "R3 collision", rd, 24'h0ABCDE);

        // R4: partial frame and parallel value without strobe have no effect
        ser_write(24'hFFFFFF, 10, 1'b0, '0);
        cal_value = 24'h555555;
        tick();
        ser_read(rd);
        check(rd == 24'h0ABCDE, "R4 held value", rd, 24'h0ABCDE);
        gain = 24'h400000; ofs_bypass = 1'b0; twos_fmt = 1'b1; unipolar = 1'b0;
        send(24'h0ABCDE, "R4 held offset in use");
        drain();

        // R10: settings change while a sample is in flight
        ofs_bypass = 1'b1; twos_fmt = 1'b1; gain = 24'h400000;
        send_exp(24'd1, 20'h00001, "R10 settings captured");
        twos_fmt = 1'b0; gain = 24'h000000; unipolar = 1'b1;
        drain();

        // Random phase: R2, R5-R10
        for (int n = 0; n < 1500; n++) begin
            if ($urandom_range(0, 63) == 0) begin
                logic [23:0] v;
                v = 24'($urandom);
                if ($urandom_range(0, 1) == 0) ser_write(v, 24, 1'b0, '0);
                else par_load(v);
                ser_read(rd);
                check(rd == model_ofs, "R2 random readback", rd, model_ofs);
            end
            ofs_bypass = $urandom_range(0, 1) == 1;
            unipolar   = $urandom_range(0, 1) == 1;
            twos_fmt   = $urandom_range(0, 1) == 1;
            gain       = 24'($urandom);
            if ($urandom_range(0, 3) == 0) begin
                tick();
            end else if ($urandom_range(0, 1) == 0) begin
                send(24'($urandom), "R6 random sample");
            end else begin
                send(24'($signed($urandom_range(0, 600000)) - 300000), "R7 random small sample");
            end
        end
        drain();
        check(exp_q.size() == 0, "R10 all results delivered", exp_q.size(), 0);

        summary();
        $finish;
    end

endmodule